// File: doc/BRIEF.md
# Two-Pass 8x8 Inverse DCT Engine

This block turns one 8x8 block of signed frequency coefficients into an 8x8 block of 8-bit pixels. It works as two one-dimensional matrix products. The first pass forms T = S'·C, row by row. The second pass forms S = Cᵀ·T, column by column. C is the fixed-point cosine matrix. The intermediate T matrix sits in an internal dual-port RAM. The coefficient block is read from an external synchronous RAM through a read port.

Three signed multipliers do all the arithmetic. In each pass they work on three neighbouring outputs at once, so that one operand fetch per cycle feeds all three lanes. The second pass begins issuing in the cycle after the first pass issues its last read. The multipliers therefore see no drain gap between the passes.

The host pulses `start` once. It then sees the pixels stream out on a write port, and `done` pulses once the block is finished.

Top module: `idct8x8_engine`

## Requirements
- R1: Each first-pass value is T[r][c] = (Σj S'[r][j]·C[j][c] + 128) >>> 8. This is an arithmetic shift, and the value is held at 20 bits signed.
- R2: Each pixel is S[m][n] = clip((Σk C[k][m]·T[k][n] + 32768) >>> 16, 0, 255). It is written at pixWrAddr = 8·m + n, so m is the row and n the column.
- R3: The cosine entries are C[k][n] = round(4096·a(k)·cos((2n+1)kπ/16)), where a(0) = √(1/8) and a(k>0) = 1/2. This gives the magnitudes 1448 for k = 0 and 2048, 2009, 1892, 1703, 1448, 1138, 784, 400 for cos(pπ/16), p = 0..7.
- R4: coefRdEn is high in exactly 192 cycles per block, and the first of them is the cycle after the one in which start is sampled. coefRdAddr = 8·row + column, and the RAM returns data in the next cycle. Within one row the successive addresses rise by one.
- R5: Each block writes exactly 64 pixels, each address once. pixWrEn is never high in more than three consecutive cycles.
- R6: done is high for exactly one cycle. That cycle is the 388th after the one in which start is sampled, and it directly follows the last pixel write.
- R7: A start pulse that arrives while a block is in progress has no effect on the latency, the read count or the pixels.
- R8: While rstN is low, done, pixWrEn and coefRdEn are low. A reset in the middle of a block abandons it, and the next start runs a full, correct block.
- R9: The second pass starts issuing in the cycle after the first pass's last read. Over the 384 issue cycles, 1024 of the 1152 multiplier slots do useful products, which is about 88.9 %.
- R10: coefRdEn and pixWrEn are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block (ignored while busy) |
| done | output | 1 | One-cycle pulse after the last pixel |
| coefRdEn | output | 1 | Coefficient RAM read strobe |
| coefRdAddr | output | 6 | Coefficient address, 8·row + column |
| coefRdData | input | 12 | Signed coefficient, valid one cycle after the address |
| pixWrEn | output | 1 | Pixel write strobe |
| pixWrAddr | output | 6 | Pixel address, 8·row + column |
| pixWrData | output | 8 | Unsigned clipped pixel |

## Verification
The assertions assume that the coefficient RAM answers exactly one cycle after the address, and that start arrives only after a reset has been released. They also assume the coefficient magnitudes keep every T value inside 20 bits. The stimulus meets all three. The bench RAM model is a plain registered read. Reset is held low for several edges before the first start. Every generated coefficient stays within the 12-bit signed range, so even a worst-case row sum of eight products stays far below the T width.

// File: rtl/idct_pkg.sv
package idct_pkg;
  localparam int BLK      = 8;
  localparam int LANES    = 3;
  localparam int GROUPS   = (BLK + LANES - 1) / LANES;
  localparam int SUB_W    = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int LANE_W   = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int IDX_W    = $clog2(BLK);
  localparam int COS_W    = 16;
  localparam int COS_FRAC = 12;

  // strobes from control to datapath
  typedef struct packed {
    logic             issue;
    logic             pass2;
    logic [IDX_W-1:0] step;
    logic [SUB_W-1:0] sub;
    logic [IDX_W-1:0] outer;
  } ctrlT;

  // cosine matrix entry C[k][n], scaled by 2^COS_FRAC; columns past the block give 0
  function automatic logic signed [COS_W-1:0] cosEntry(input int k, input int n);
    int p;
    int m;
    int mag;
    logic neg;
    if (n >= BLK) return '0;
    if (k == 0) return COS_W'(1448);
    p = ((2 * n + 1) * k) % (4 * BLK);
    neg = 1'b0;
    m = p;
    if (p > 3 * BLK) m = 4 * BLK - p;
    else if (p > BLK) begin
      neg = 1'b1;
      m = (p > 2 * BLK) ? p - 2 * BLK : 2 * BLK - p;
    end
    case (m)
      0: mag = 2048;
      1: mag = 2009;
      2: mag = 1892;
      3: mag = 1703;
      4: mag = 1448;
      5: mag = 1138;
      6: mag = 784;
      7: mag = 400;
      default: mag = 0;
    endcase
    return neg ? COS_W'(-mag) : COS_W'(mag);
  endfunction
endpackage

// File: rtl/idct_tram.sv
module idct_tram #(
  parameter int W     = 20,
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] wa,
  input  logic [W-1:0]             wd,
  input  logic [$clog2(DEPTH)-1:0] ra,
  output logic [W-1:0]             rd
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end
endmodule

// File: rtl/idct_ctrl.sv
module idct_ctrl
  import idct_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic lastPix,
  output ctrlT ctl,
  output logic done
);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(GROUPS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BLK - 1);

  logic             busy, issuing, pass2;
  logic [IDX_W-1:0] step, outer;
  logic [SUB_W-1:0] sub;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      issuing <= 1'b0;
      pass2   <= 1'b0;
      step    <= '0;
      outer   <= '0;
      sub     <= '0;
      done    <= 1'b0;
    end else begin
      done <= lastPix;
      if (lastPix) busy <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        issuing <= 1'b1;
        pass2   <= 1'b0;
        step    <= '0;
        outer   <= '0;
        sub     <= '0;
      end else if (issuing) begin
        step <= step + 1'b1;
        if (step == IDX_LAST) begin
          if (sub == SUB_LAST) begin
            sub   <= '0;
            outer <= outer + 1'b1;
            if (outer == IDX_LAST) begin
              if (pass2) issuing <= 1'b0;
              pass2 <= 1'b1;   // second pass follows with no gap
            end
          end else begin
            sub <= sub + 1'b1;
          end
        end
      end
    end
  end

  assign ctl.issue = issuing;
  assign ctl.pass2 = pass2;
  assign ctl.step  = step;
  assign ctl.sub   = sub;
  assign ctl.outer = outer;
endmodule

// File: rtl/idct_dpath.sv
module idct_dpath
  import idct_pkg::*;
#(
  parameter int COEF_W  = 12,
  parameter int T_W     = 20,
  parameter int ACC_W   = 40,
  parameter int T_SHIFT = 8,
  parameter int PIX_W   = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlT                     ctl,
  output logic                     coefRdEn,
  output logic [2*IDX_W-1:0]       coefRdAddr,
  input  logic signed [COEF_W-1:0] coefRdData,
  output logic                     pixWrEn,
  output logic [2*IDX_W-1:0]       pixWrAddr,
  output logic [PIX_W-1:0]         pixWrData,
  output logic                     lastPix
);
  localparam int OUT_SH  = 2 * COS_FRAC - T_SHIFT;
  localparam int PROD_W  = T_W + COS_W;
  localparam int PIX_MAX = (1 << PIX_W) - 1;
  localparam logic signed [ACC_W-1:0] T_RND = ACC_W'(64'sd1 <<< (T_SHIFT - 1));
  localparam logic signed [ACC_W-1:0] P_RND = ACC_W'(64'sd1 <<< (OUT_SH - 1));
  localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(BLK - 1);
  localparam logic [LANE_W-1:0] LANE_LAST = LANE_W'(LANES - 1);

  // issue stage: addresses straight from the counters
  assign coefRdEn   = ctl.issue & ~ctl.pass2;
  assign coefRdAddr = {ctl.outer, ctl.step};

  // operand stage
  logic             v1, p2s1, first1, last1;
  logic [IDX_W-1:0] outer1;
  logic [SUB_W-1:0] sub1;
  logic [T_W-1:0]   tRdData;
  logic signed [T_W-1:0] opA;
  logic signed [T_W-1:0] holdArr [LANES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1 <= 1'b0; p2s1 <= 1'b0; first1 <= 1'b0; last1 <= 1'b0;
      outer1 <= '0; sub1 <= '0;
    end else begin
      v1     <= ctl.issue;
      p2s1   <= ctl.pass2;
      first1 <= (ctl.step == '0);
      last1  <= (ctl.step == IDX_LAST);
      outer1 <= ctl.outer;
      sub1   <= ctl.sub;
    end
  end

  assign opA = p2s1 ? $signed(tRdData) : T_W'(coefRdData);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [COS_W-1:0]  cosQ;
    logic signed [ACC_W-1:0]  acc, sum, rT, rP;
    logic signed [PROD_W-1:0] prod;
    logic signed [T_W-1:0]    holdR, nextHold;

    assign prod = opA * cosQ;
    assign sum  = first1 ? ACC_W'(prod) : acc + ACC_W'(prod);

    always_comb begin
      rT = (sum + T_RND) >>> T_SHIFT;
      rP = (sum + P_RND) >>> OUT_SH;
      if (!p2s1)              nextHold = rT[T_W-1:0];
      else if (rP < 0)        nextHold = '0;
      else if (rP > PIX_MAX)  nextHold = T_W'(PIX_MAX);
      else                    nextHold = rP[T_W-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cosQ <= '0; acc <= '0; holdR <= '0;
      end else begin
        cosQ <= cosEntry(int'(ctl.step), int'(ctl.sub) * LANES + l);
        if (v1) acc <= sum;
        if (v1 && last1) holdR <= nextHold;
      end
    end

    assign holdArr[l] = holdR;
  end

  // write stage: three results drain one per cycle
  logic              wrActive, wrP2;
  logic [IDX_W-1:0]  wrOuter, colIdx;
  logic [SUB_W-1:0]  wrSub;
  logic [LANE_W-1:0] wrLane;
  logic              laneValid, tWrEn;
  logic signed [T_W-1:0] holdSel;
  int laneCol;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrActive <= 1'b0; wrP2 <= 1'b0; wrOuter <= '0; wrSub <= '0; wrLane <= '0;
    end else if (v1 && last1) begin
      wrActive <= 1'b1; wrP2 <= p2s1; wrOuter <= outer1; wrSub <= sub1; wrLane <= '0;
    end else if (wrActive) begin
      if (wrLane == LANE_LAST) wrActive <= 1'b0;
      wrLane <= wrLane + 1'b1;
    end
  end

  assign laneCol   = int'(wrSub) * LANES + int'(wrLane);
  assign laneValid = wrActive && (laneCol < BLK);
  assign colIdx    = IDX_W'(laneCol);
  assign holdSel   = (int'(wrLane) < LANES) ? holdArr[wrLane] : '0;
  assign tWrEn     = laneValid && !wrP2;
  assign pixWrEn   = laneValid && wrP2;
  assign pixWrAddr = {colIdx, wrOuter};
  assign pixWrData = holdSel[PIX_W-1:0];
  assign lastPix   = pixWrEn && (wrOuter == IDX_LAST) && (colIdx == IDX_LAST);

  idct_tram #(.W(T_W), .DEPTH(BLK * BLK)) u_tram (
    .clk (clk),
    .we  (tWrEn),
    .wa  ({wrOuter, colIdx}),
    .wd  (holdSel),
    .ra  ({ctl.step, ctl.outer}),
    .rd  (tRdData)
  );
endmodule

// File: rtl/idct8x8_engine.sv
module idct8x8_engine
  import idct_pkg::*;
#(
  parameter int COEF_W  = 12,
  parameter int T_W     = 20,
  parameter int ACC_W   = 40,
  parameter int T_SHIFT = 8,
  parameter int PIX_W   = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  output logic                     done,
  output logic                     coefRdEn,
  output logic [2*IDX_W-1:0]       coefRdAddr,
  input  logic signed [COEF_W-1:0] coefRdData,
  output logic                     pixWrEn,
  output logic [2*IDX_W-1:0]       pixWrAddr,
  output logic [PIX_W-1:0]         pixWrData
);
  ctrlT ctl;
  logic lastPix;

  idct_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .lastPix (lastPix),
    .ctl     (ctl),
    .done    (done)
  );

  idct_dpath #(
    .COEF_W (COEF_W), .T_W (T_W), .ACC_W (ACC_W), .T_SHIFT (T_SHIFT), .PIX_W (PIX_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .coefRdEn   (coefRdEn),
    .coefRdAddr (coefRdAddr),
    .coefRdData (coefRdData),
    .pixWrEn    (pixWrEn),
    .pixWrAddr  (pixWrAddr),
    .pixWrData  (pixWrData),
    .lastPix    (lastPix)
  );
endmodule

// File: rtl/idct_checker.sv
module idct_checker (
  input logic       clk,
  input logic       rstN,
  input logic       done,
  input logic       coefRdEn,
  input logic [5:0] coefRdAddr,
  input logic       pixWrEn
);
  // R6: the completion pulse lasts a single cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: completion directly follows a pixel write
  a_r6_done_after_write: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(pixWrEn));

  // R10: input reads and output writes never share a cycle
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(coefRdEn && pixWrEn));

  // R4: reads inside one row advance by one
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (coefRdEn && $past(coefRdEn) && (coefRdAddr[2:0] != 3'd0))
      |-> (coefRdAddr == $past(coefRdAddr) + 6'd1));

  // R5: write bursts are at most three long
  a_r5_burst_max: assert property (@(posedge clk) disable iff (!rstN)
    (pixWrEn && $past(pixWrEn) && $past(pixWrEn, 2)) |=> !pixWrEn);
endmodule

bind idct8x8_engine idct_checker u_chk (.*);

// File: tb/idct8x8_engine_bench.sv
module idct8x8_engine_bench;
  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic              done, coefRdEn, pixWrEn;
  logic [5:0]        coefRdAddr, pixWrAddr;
  logic signed [11:0] coefRdData;
  logic [7:0]        pixWrData;

  idct8x8_engine u_idct8x8_engine (
    .clk (clk), .rstN (rstN), .start (start), .done (done),
    .coefRdEn (coefRdEn), .coefRdAddr (coefRdAddr), .coefRdData (coefRdData),
    .pixWrEn (pixWrEn), .pixWrAddr (pixWrAddr), .pixWrData (pixWrData)
  );

  always #4 clk = ~clk;

  // stimulus table: {kind[3:0], amplitude[11:0] signed, seed[15:0]}
  // kind 0 zero, 1 DC only, 2 DC 1024 + one coefficient, 3 pseudo-random AC, 4 checkerboard AC
  localparam logic [31:0] VEC [10] = '{
    {4'd0, 12'd0,    16'd0},
    {4'd1, 12'd1024, 16'd0},
    {4'd1, 12'd2047, 16'd0},
    {4'd1, 12'hC00,  16'd0},
    {4'd2, 12'd600,  16'd1},
    {4'd2, 12'hE0C,  16'd8},
    {4'd3, 12'd200,  16'd1234},
    {4'd3, 12'd511,  16'd777},
    {4'd4, 12'd300,  16'd0},
    {4'd2, 12'd900,  16'd63}
  };

  int checks = 0;
  int failures = 0;
  logic signed [11:0] coefMem [64];
  int pixMem [64];
  int hits [64];
  int expPix [64];
  int rdCycles = 0;

  always @(posedge clk) begin
    coefRdData <= coefMem[coefRdAddr];
    if (pixWrEn) begin
      pixMem[pixWrAddr] = int'(pixWrData);
      hits[pixWrAddr] = hits[pixWrAddr] + 1;
    end
    if (coefRdEn) rdCycles = rdCycles + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R3: cosine entry from its definition
  function automatic longint cosv(input int k, input int n);
    real a, v;
    a = (k == 0) ? $sqrt(1.0 / 8.0) * 4096.0 : 2048.0;
    v = a * $cos(real'((2 * n + 1) * k) * 3.14159265358979 / 16.0);
    return (v >= 0.0) ? longint'($rtoi(v + 0.5)) : longint'($rtoi(v - 0.5));
  endfunction

  task automatic buildBlock(input logic [31:0] vec);
    int kind, amp, seed, s, v;
    kind = int'(vec[31:28]);
    amp  = int'($signed(vec[27:16]));
    seed = int'(vec[15:0]);
    for (int i = 0; i < 64; i++) coefMem[i] = '0;
    s = seed;
    case (kind)
      1: coefMem[0] = 12'(amp);
      2: begin coefMem[0] = 12'sd1024; coefMem[seed[5:0]] = 12'(amp); end
      3: begin
        coefMem[0] = 12'sd1024;
        for (int i = 1; i < 64; i++) begin
          s = s * 1103515245 + 12345;
          v = ((s >> 8) & 1023) - 512;
          coefMem[i] = 12'(v * amp / 512);
        end
      end
      4: begin
        coefMem[0] = 12'sd1024;
        for (int i = 1; i < 64; i++) coefMem[i] = (((i >> 3) + (i & 7)) % 2 == 1) ? 12'(amp) : 12'(-amp);
      end
      default: ;
    endcase
  endtask

  // R1, R2: fixed-point reference
  task automatic computeExpected();
    longint tm [64];
    longint acc, v;
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) begin
        acc = 0;
        for (int j = 0; j < 8; j++) acc += longint'(coefMem[r * 8 + j]) * cosv(j, c);
        tm[r * 8 + c] = (acc + 128) >>> 8;
      end
    for (int m = 0; m < 8; m++)
      for (int n = 0; n < 8; n++) begin
        acc = 0;
        for (int k = 0; k < 8; k++) acc += cosv(k, m) * tm[k * 8 + n];
        v = (acc + 32768) >>> 16;
        expPix[m * 8 + n] = (v < 0) ? 0 : (v > 255) ? 255 : int'(v);
      end
  endtask

  task automatic runBlock(input logic [31:0] vec, input bit extraStart);
    int cnt, firstRd, badHits, badPix, badIdx;
    buildBlock(vec);
    computeExpected();
    for (int i = 0; i < 64; i++) begin hits[i] = 0; pixMem[i] = -1; end
    rdCycles = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cnt = 1;
    firstRd = coefRdEn ? 1 : 0;
    while (!done && cnt < 1000) begin
      @(negedge clk);
      cnt++;
      start = extraStart && (cnt == 100);   // R7: pulse while busy
    end
    start = 1'b0;
    check(cnt == 388, "R6", "done cycle after start (R9 no pass gap)", cnt, 388);
    check(rdCycles == 192 && firstRd == 1, "R4", "coefficient read cycles", rdCycles, 192);
    badHits = 0;
    for (int i = 0; i < 64; i++) if (hits[i] != 1) badHits++;
    check(badHits == 0, "R5", "addresses not written exactly once", badHits, 0);
    badPix = 0;
    badIdx = 0;
    for (int i = 0; i < 64; i++)
      if (pixMem[i] != expPix[i]) begin
        if (badPix == 0) badIdx = i;
        badPix++;
      end
    check(badPix == 0, extraStart ? "R7" : "R2", "pixel value (R1 R3)",
          pixMem[badIdx], expPix[badIdx]);
    @(negedge clk);
    check(done == 1'b0, "R6", "done width", done, 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) coefMem[i] = '0;
    repeat (3) @(negedge clk);
    check(!done && !pixWrEn && !coefRdEn, "R8", "outputs in reset",
          {done, pixWrEn, coefRdEn}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!done && !pixWrEn && !coefRdEn, "R8", "outputs idle after reset",
          {done, pixWrEn, coefRdEn}, 0);

    for (int v = 0; v < 10; v++) runBlock(VEC[v], v == 6);

    // R8: reset in the middle of a block, then a clean block
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (250) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(!done && !pixWrEn && !coefRdEn, "R8", "outputs during mid-block reset",
          {done, pixWrEn, coefRdEn}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    runBlock(VEC[7], 1'b0);

    // back-to-back blocks with a second ignored start (R7)
    runBlock(VEC[8], 1'b1);
    runBlock(VEC[2], 1'b0);

    summary();
    $finish;
  end
endmodule